// File: doc/BRIEF.md
# EEPROM Serial Command Decoder

This block interprets the command bytes of a two-wire serial EEPROM once a bit-level front end has assembled them. The memory has a 1024-byte main array and two small special pages: a protection page and an identification page. For every byte the front end delivers, the decoder returns one response a cycle later. The response holds an ACK or NACK decision, the phase the byte belonged to (device select, word address or data), the target it addressed, the direction, and the byte offset inside that target. The storage uses the offset. The front end uses the ACK bit.

Main-array commands place two high address bits in the device-select byte and the low eight bits in the word-address byte. Two device-select values are reserved for the special pages. In a special-page command the word address must fit in 0x00..0x1F, bit 4 picks the page, and at most one data byte may be transferred. The decoder keeps a main-array pointer and the most recently addressed special-page location, so a read command without a word address continues from there. Bus start and stop indications restart its sequence.

Top module: `eep_cmd_decode`

## Requirements
- R1: While reset is high, and on the first cycle after it, rsp_vld is 0. After reset the main pointer is 0 and the latched special location is the protection page, offset 0.
- R2: A byte strobe with neither bus_start nor bus_stop asserted gets exactly one response, with rsp_vld high on the following cycle. rsp_vld is low in every other cycle.
- R3: The first byte after a start is the device select. Values 0xA8..0xAF are ACKed with target main (rsp_tgt 1) and rsp_rd equal to bit 0. Bits [2:1] become address bits [9:8].
- R4: Any device-select value other than 0xA8..0xAF, 0xB8 or 0xB9 is NACKed. Every later byte is NACKed until the next start.
- R5: Device selects 0xB8 (write) and 0xB9 (read) are always ACKed. The response reports the latched special page as its target.
- R6: In a main write, the word address is ACKed with offset {select bits [2:1], address byte}. It also loads the low byte of the main pointer.
- R7: In a special write, a word address with any of bits [7:5] set is NACKed. The decoder then NACKs every byte until the next start.
- R8: In a special write, an accepted word address selects the identification page (rsp_tgt 3) when bit 4 is 1, or the protection page (rsp_tgt 2) when it is 0. The offset is bits [3:0]. Both are latched.
- R9: The first data byte of a special access is ACKed at the latched page and offset. The second and every later data byte are NACKed.
- R10: Main data bytes are ACKed at increasing offsets. The offset wraps from 0x3FF to 0x000. Each one leaves the pointer's low byte at the next offset.
- R11: A read select starts data directly. For a main read the offset is {select bits [2:1], pointer low byte}. For a special read it is the latched page and offset.
- R12: bus_start returns the decoder to device-select phase and bus_stop returns it to idle. Either one clears the special-transfer state. A byte strobed in the same cycle as either is dropped with no response. A byte strobed while idle is NACKed.
- R13: Every NACK response carries target none (0), offset 0 and rsp_rd 0. rsp_phase encodes device select as 1, word address as 2, data as 3, and idle or rejected-state bytes as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | A received byte is present this cycle |
| byte_in | input | 8 | Received byte value |
| bus_start | input | 1 | Start or repeated start seen on the bus |
| bus_stop | input | 1 | Stop seen on the bus |
| rsp_vld | output | 1 | Response for the byte of the previous cycle |
| rsp_ack | output | 1 | 1 = acknowledge, 0 = not acknowledge |
| rsp_phase | output | 2 | Phase of the byte answered |
| rsp_tgt | output | 2 | 0 none, 1 main array, 2 protection page, 3 identification page |
| rsp_rd | output | 1 | Transfer direction, 1 = read |
| rsp_off | output | 10 | Byte offset inside the target |

## Verification
A wrong sequencer state shows on the response to the very next byte. It appears as a wrong phase code, as an ACK where a NACK belongs, or as the reverse. A corrupted main pointer or latched special location stays hidden until a read select with no word address, or the next data byte, and then shows as a wrong offset or target. A special-transfer flag that is lost or left stale turns page offsets into main-array offsets on the following byte. It can also lets a second data byte through. Because these faults stay hidden until the right command arrives, the sequences interleave address-only writes with later read selects.

// File: rtl/eep_cmd_pkg.sv
package eep_cmd_pkg;

    localparam int BYTE_W = 8;

    // device-select prefixes (upper bits of the first byte)
    localparam logic [4:0] MAIN_PFX = 5'b10101;   // 0xA8..0xAF
    localparam logic [6:0] SPEC_PFX = 7'b1011100; // 0xB8 / 0xB9

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_MAIN  = 2'd1,
        TGT_PROT  = 2'd2,
        TGT_IDENT = 2'd3
    } tgt_e;

    typedef enum logic [1:0] {
        PH_NONE = 2'd0,
        PH_DEV  = 2'd1,
        PH_WADR = 2'd2,
        PH_DATA = 2'd3
    } phase_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_DEV  = 3'd1,
        ST_WADR = 3'd2,
        ST_DATA = 3'd3,
        ST_HOLD = 3'd4
    } seq_st_e;

    typedef enum logic [1:0] {
        DS_BAD  = 2'd0,
        DS_MAIN = 2'd1,
        DS_SPEC = 2'd2
    } dsel_kind_e;

    typedef struct packed {
        dsel_kind_e kind;
        logic       rd;
    } dsel_t;

    typedef struct packed {
        logic   ack;
        phase_e phase;
        tgt_e   tgt;
        logic   rd;
    } rsp_hdr_t;

    function automatic dsel_kind_e classify_dsel(input logic [BYTE_W-1:0] b);
        if (b[7:3] == MAIN_PFX)      return DS_MAIN;
        else if (b[7:1] == SPEC_PFX) return DS_SPEC;
        else                         return DS_BAD;
    endfunction

    function automatic rsp_hdr_t nack_hdr(input phase_e ph);
        rsp_hdr_t h;
        h.ack   = 1'b0;
        h.phase = ph;
        h.tgt   = TGT_NONE;
        h.rd    = 1'b0;
        return h;
    endfunction

endpackage

// File: rtl/eep_devsel_dec.sv
module eep_devsel_dec
    import eep_cmd_pkg::*;
#(
    parameter int HI_W = 2
) (
    input  logic [BYTE_W-1:0] sel_byte,
    output dsel_t             dsel,
    output logic [HI_W-1:0]   hi_bits
);
    always_comb begin
        dsel.kind = classify_dsel(sel_byte);
        dsel.rd   = sel_byte[0];
    end

    // block bits sit just above the direction bit; upper ones are dropped
    assign hi_bits = sel_byte[HI_W:1];
endmodule

// File: rtl/eep_spaddr_dec.sv
module eep_spaddr_dec
    import eep_cmd_pkg::*;
#(
    parameter int SPG_AW = 4
) (
    input  logic [BYTE_W-1:0] adr_byte,
    output logic              in_range,
    output tgt_e              page,
    output logic [SPG_AW-1:0] page_off
);
    localparam int TOP_LSB = SPG_AW + 1;

    assign in_range = (adr_byte[BYTE_W-1:TOP_LSB] == '0);
    assign page     = adr_byte[SPG_AW] ? TGT_IDENT : TGT_PROT;
    assign page_off = adr_byte[SPG_AW-1:0];
endmodule

// File: rtl/eep_cmd_seq.sv
module eep_cmd_seq
    import eep_cmd_pkg::*;
#(
    parameter int MAIN_AW = 10,
    parameter int SPG_AW  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               byte_vld,
    input  logic [BYTE_W-1:0]  byte_in,
    input  logic               bus_start,
    input  logic               bus_stop,
    input  dsel_t              dsel,
    input  logic [MAIN_AW-9:0] dsel_hi,
    input  logic               sp_ok,
    input  tgt_e               sp_page,
    input  logic [SPG_AW-1:0]  sp_off,
    output logic               rsp_vld,
    output rsp_hdr_t           rsp_hdr,
    output logic [MAIN_AW-1:0] rsp_off,
    output seq_st_e            st,
    output logic               spec
);
    localparam int HI_W = MAIN_AW - BYTE_W;

    logic [HI_W-1:0]    hi_q, hi_d;
    logic               rd_q, rd_d;
    logic               used_q, used_d;
    logic               spec_d;
    logic [MAIN_AW-1:0] cur_q, cur_d, cur_inc;
    logic [BYTE_W-1:0]  mptr_q, mptr_d;
    tgt_e               pg_q, pg_d;
    logic [SPG_AW-1:0]  so_q, so_d;
    seq_st_e            st_d;
    logic               accept;
    rsp_hdr_t           hdr_d;
    logic [MAIN_AW-1:0] off_d;

    assign accept  = byte_vld && !bus_start && !bus_stop;
    assign cur_inc = cur_q + 1'b1;

    always_comb begin
        st_d   = st;
        spec_d = spec;
        used_d = used_q;
        rd_d   = rd_q;
        hi_d   = hi_q;
        cur_d  = cur_q;
        mptr_d = mptr_q;
        pg_d   = pg_q;
        so_d   = so_q;
        hdr_d  = nack_hdr(PH_NONE);
        off_d  = '0;

        if (bus_start) begin
            st_d   = ST_DEV;
            spec_d = 1'b0;
            used_d = 1'b0;
        end else if (bus_stop) begin
            st_d   = ST_IDLE;
            spec_d = 1'b0;
            used_d = 1'b0;
        end else if (byte_vld) begin
            unique case (st)
                ST_DEV: begin
                    hdr_d = nack_hdr(PH_DEV);
                    unique case (dsel.kind)
                        DS_MAIN: begin
                            hdr_d.ack = 1'b1;
                            hdr_d.tgt = TGT_MAIN;
                            hdr_d.rd  = dsel.rd;
                            rd_d      = dsel.rd;
                            hi_d      = dsel_hi;
                            spec_d    = 1'b0;
                            if (dsel.rd) begin
                                cur_d = {dsel_hi, mptr_q};
                                st_d  = ST_DATA;
                            end else begin
                                st_d  = ST_WADR;
                            end
                        end
                        DS_SPEC: begin
                            hdr_d.ack = 1'b1;
                            hdr_d.tgt = pg_q;
                            hdr_d.rd  = dsel.rd;
                            rd_d      = dsel.rd;
                            spec_d    = 1'b1;
                            used_d    = 1'b0;
                            st_d      = dsel.rd ? ST_DATA : ST_WADR;
                        end
                        default: st_d = ST_HOLD;
                    endcase
                end
                ST_WADR: begin
                    hdr_d = nack_hdr(PH_WADR);
                    if (spec) begin
                        if (sp_ok) begin
                            hdr_d.ack = 1'b1;
                            hdr_d.tgt = sp_page;
                            off_d[SPG_AW-1:0] = sp_off;
                            pg_d = sp_page;
                            so_d = sp_off;
                            st_d = ST_DATA;
                        end else begin
                            st_d = ST_HOLD;
                        end
                    end else begin
                        hdr_d.ack = 1'b1;
                        hdr_d.tgt = TGT_MAIN;
                        off_d     = {hi_q, byte_in};
                        cur_d     = {hi_q, byte_in};
                        mptr_d    = byte_in;
                        st_d      = ST_DATA;
                    end
                end
                ST_DATA: begin
                    hdr_d = nack_hdr(PH_DATA);
                    if (spec) begin
                        if (!used_q) begin
                            hdr_d.ack = 1'b1;
                            hdr_d.tgt = pg_q;
                            hdr_d.rd  = rd_q;
                            off_d[SPG_AW-1:0] = so_q;
                            used_d = 1'b1;
                        end else begin
                            st_d = ST_HOLD;
                        end
                    end else begin
                        hdr_d.ack = 1'b1;
                        hdr_d.tgt = TGT_MAIN;
                        hdr_d.rd  = rd_q;
                        off_d     = cur_q;
                        cur_d     = cur_inc;
                        mptr_d    = cur_inc[BYTE_W-1:0];
                    end
                end
                default: hdr_d = nack_hdr(PH_NONE);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            spec    <= 1'b0;
            used_q  <= 1'b0;
            rd_q    <= 1'b0;
            hi_q    <= '0;
            cur_q   <= '0;
            mptr_q  <= '0;
            pg_q    <= TGT_PROT;
            so_q    <= '0;
            rsp_vld <= 1'b0;
            rsp_hdr <= nack_hdr(PH_NONE);
            rsp_off <= '0;
        end else begin
            st      <= st_d;
            spec    <= spec_d;
            used_q  <= used_d;
            rd_q    <= rd_d;
            hi_q    <= hi_d;
            cur_q   <= cur_d;
            mptr_q  <= mptr_d;
            pg_q    <= pg_d;
            so_q    <= so_d;
            rsp_vld <= accept;
            if (accept) begin
                rsp_hdr <= hdr_d;
                rsp_off <= off_d;
            end
        end
    end
endmodule

// File: rtl/eep_cmd_decode.sv
module eep_cmd_decode
    import eep_cmd_pkg::*;
#(
    parameter int MAIN_AW = 10,
    parameter int SPG_AW  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               byte_vld,
    input  logic [7:0]         byte_in,
    input  logic               bus_start,
    input  logic               bus_stop,
    output logic               rsp_vld,
    output logic               rsp_ack,
    output logic [1:0]         rsp_phase,
    output logic [1:0]         rsp_tgt,
    output logic               rsp_rd,
    output logic [MAIN_AW-1:0] rsp_off
);
    localparam int HI_W = MAIN_AW - BYTE_W;

    dsel_t             dsel;
    logic [HI_W-1:0]   dsel_hi;
    logic              sp_ok;
    tgt_e              sp_page;
    logic [SPG_AW-1:0] sp_off;
    rsp_hdr_t          hdr;
    seq_st_e           seq_st;
    logic              seq_spec;

    eep_devsel_dec #(.HI_W(HI_W)) u_devsel (
        .sel_byte (byte_in),
        .dsel     (dsel),
        .hi_bits  (dsel_hi)
    );

    eep_spaddr_dec #(.SPG_AW(SPG_AW)) u_spaddr (
        .adr_byte (byte_in),
        .in_range (sp_ok),
        .page     (sp_page),
        .page_off (sp_off)
    );

    eep_cmd_seq #(.MAIN_AW(MAIN_AW), .SPG_AW(SPG_AW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .byte_vld  (byte_vld),
        .byte_in   (byte_in),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .dsel      (dsel),
        .dsel_hi   (dsel_hi),
        .sp_ok     (sp_ok),
        .sp_page   (sp_page),
        .sp_off    (sp_off),
        .rsp_vld   (rsp_vld),
        .rsp_hdr   (hdr),
        .rsp_off   (rsp_off),
        .st        (seq_st),
        .spec      (seq_spec)
    );

    assign rsp_ack   = hdr.ack;
    assign rsp_phase = hdr.phase;
    assign rsp_tgt   = hdr.tgt;
    assign rsp_rd    = hdr.rd;
endmodule

module eep_cmd_decode_chk #(
    parameter int MAIN_AW = 10,
    parameter int SPG_AW  = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               byte_vld,
    input logic [7:0]         byte_in,
    input logic               bus_start,
    input logic               bus_stop,
    input logic               rsp_vld,
    input logic               rsp_ack,
    input logic [1:0]         rsp_tgt,
    input logic               rsp_rd,
    input logic [MAIN_AW-1:0] rsp_off,
    input logic [2:0]         seq_st,
    input logic               seq_spec
);
    logic take;
    assign take = byte_vld && !bus_start && !bus_stop;

    // R2
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> rsp_vld);

    // R2
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !take |=> !rsp_vld);

    // R13
    nack_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && !rsp_ack) |-> (rsp_tgt == 2'd0 && rsp_off == '0 && !rsp_rd));

    // R5
    spec_sel_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (take && seq_st == 3'd1 && byte_in[7:1] == 7'b1011100) |=> rsp_ack);

    // R7
    spaddr_range_chk: assert property (@(posedge clk) disable iff (rst)
        (take && seq_st == 3'd2 && seq_spec && (byte_in >> (SPG_AW + 1)) != 8'd0)
        |=> !rsp_ack);

    // R4
    hold_nack_chk: assert property (@(posedge clk) disable iff (rst)
        (take && seq_st == 3'd4) |=> !rsp_ack);

    // R12
    stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_stop && !bus_start) |=> (seq_st == 3'd0 && !seq_spec));
endmodule

bind eep_cmd_decode eep_cmd_decode_chk #(.MAIN_AW(MAIN_AW), .SPG_AW(SPG_AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .byte_vld  (byte_vld),
    .byte_in   (byte_in),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .rsp_vld   (rsp_vld),
    .rsp_ack   (rsp_ack),
    .rsp_tgt   (rsp_tgt),
    .rsp_rd    (rsp_rd),
    .rsp_off   (rsp_off),
    .seq_st    (seq_st),
    .seq_spec  (seq_spec)
);

// File: tb/eep_cmd_decode_bench.sv
module eep_cmd_decode_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       bus_start = 1'b0;
    logic       bus_stop = 1'b0;
    logic       rsp_vld, rsp_ack, rsp_rd;
    logic [1:0] rsp_phase, rsp_tgt;
    logic [9:0] rsp_off;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;
    string tag = "R1 reset";

    // behavioural reference state
    int m_st = 0, m_spec = 0, m_used = 0, m_rd = 0, m_hi = 0;
    int m_cur = 0, m_mptr = 0, m_page = 2, m_soff = 0;

    always #2 clk = ~clk;

    eep_cmd_decode u_eep_cmd_decode (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_in(byte_in),
        .bus_start(bus_start), .bus_stop(bus_stop), .rsp_vld(rsp_vld),
        .rsp_ack(rsp_ack), .rsp_phase(rsp_phase), .rsp_tgt(rsp_tgt),
        .rsp_rd(rsp_rd), .rsp_off(rsp_off)
    );

    task automatic check(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        int e_v, e_ack, e_ph, e_tgt, e_rd, e_off;
        #1;
        e_v = 0; e_ack = 0; e_ph = 0; e_tgt = 0; e_rd = 0; e_off = 0;
        if (rst) begin
            m_st = 0; m_spec = 0; m_used = 0; m_rd = 0; m_hi = 0;
            m_cur = 0; m_mptr = 0; m_page = 2; m_soff = 0;
        end else if (bus_start) begin
            m_st = 1; m_spec = 0; m_used = 0;
        end else if (bus_stop) begin
            m_st = 0; m_spec = 0; m_used = 0;
        end else if (byte_vld) begin
            e_v = 1;
            if (m_st == 1) begin
                e_ph = 1;
                if (byte_in >= 8'hA8 && byte_in <= 8'hAF) begin
                    e_ack = 1; e_tgt = 1; e_rd = byte_in[0];
                    m_rd = byte_in[0]; m_hi = (byte_in / 2) % 4; m_spec = 0;
                    if (m_rd != 0) begin m_cur = m_hi * 256 + m_mptr; m_st = 3; end
                    else m_st = 2;
                end else if (byte_in == 8'hB8 || byte_in == 8'hB9) begin
                    e_ack = 1; e_tgt = m_page; e_rd = byte_in[0];
                    m_rd = byte_in[0]; m_spec = 1; m_used = 0;
                    m_st = (m_rd != 0) ? 3 : 2;
                end else m_st = 4;
            end else if (m_st == 2) begin
                e_ph = 2;
                if (m_spec != 0) begin
                    if (byte_in < 32) begin
                        e_ack = 1; m_page = (byte_in >= 16) ? 3 : 2; m_soff = byte_in % 16;
                        e_tgt = m_page; e_off = m_soff; m_st = 3;
                    end else m_st = 4;
                end else begin
                    e_ack = 1; e_tgt = 1; m_cur = m_hi * 256 + byte_in;
                    m_mptr = byte_in; e_off = m_cur; m_st = 3;
                end
            end else if (m_st == 3) begin
                e_ph = 3;
                if (m_spec != 0) begin
                    if (m_used == 0) begin
                        e_ack = 1; e_tgt = m_page; e_rd = m_rd; e_off = m_soff; m_used = 1;
                    end else m_st = 4;
                end else begin
                    e_ack = 1; e_tgt = 1; e_rd = m_rd; e_off = m_cur;
                    m_cur = (m_cur + 1) % 1024; m_mptr = m_cur % 256;
                end
            end
        end
        check("rsp_vld", int'(rsp_vld), e_v);
        if (e_v != 0) begin
            check("rsp_ack", int'(rsp_ack), e_ack);
            check("rsp_phase", int'(rsp_phase), e_ph);
            check("rsp_tgt", int'(rsp_tgt), e_tgt);
            check("rsp_rd", int'(rsp_rd), e_rd);
            check("rsp_off", int'(rsp_off), e_off);
        end
    end

    task automatic drv(input logic s, input logic p, input logic v, input logic [7:0] b);
        @(negedge clk);
        bus_start = s; bus_stop = p; byte_vld = v; byte_in = b;
    endtask

    task automatic sb(input logic [7:0] b);
        drv(0, 0, 1, b);
    endtask

    task automatic st_();
        drv(1, 0, 0, 8'h00);
    endtask

    task automatic sp_();
        drv(0, 1, 0, 8'h00);
    endtask

    task automatic gap();
        drv(0, 0, 0, 8'h00);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tag = "R1 post-reset quiet"; gap(); gap();
        tag = "R12 byte while idle"; sb(8'hA8); gap();
        tag = "R3 R6 R10 main write"; st_(); sb(8'hA8); sb(8'hFE); sb(8'h11); sb(8'h22); sb(8'h33); sp_();
        tag = "R10 wrap at top"; st_(); sb(8'hAE); sb(8'hFF); sb(8'h01); sb(8'h02); sp_(); gap();
        tag = "R11 main random read"; st_(); sb(8'hA8); sb(8'h40); st_(); sb(8'hA9); sb(8'h00); sb(8'h00); sp_();
        tag = "R11 main read other block"; st_(); sb(8'hAB); sb(8'h00); sp_();
        tag = "R5 R8 R9 ident write"; st_(); sb(8'hB8); sb(8'h13); sb(8'h5A); sb(8'h5B); sb(8'h5C); sp_();
        tag = "R11 special read"; st_(); sb(8'hB9); sb(8'h00); sb(8'h00); sp_();
        tag = "R8 prot write"; st_(); sb(8'hB8); sb(8'h0A); sb(8'h77); sp_();
        tag = "R7 address out of range"; st_(); sb(8'hB8); sb(8'h25); sb(8'h00); sp_();
        tag = "R7 high bit"; st_(); sb(8'hB8); sb(8'h80); st_(); sb(8'hB9); sb(8'h00);
        tag = "R4 bad codes"; st_(); sb(8'h50); sb(8'hA8); sb(8'h00);
        st_(); sb(8'hBA); sb(8'h00); st_(); sb(8'hA7); sb(8'h01); sp_();
        tag = "R12 byte with start/stop";
        drv(1, 0, 1, 8'h11); sb(8'hA8); drv(0, 1, 1, 8'h22); sb(8'hA8); gap();
        tag = "R12 repeated start clears special";
        st_(); sb(8'hB8); sb(8'h02); sb(8'h01); st_(); sb(8'hA8); sb(8'h10); sb(8'h99); sp_();
        tag = "R2 R13 back-to-back mix";
        for (int i = 0; i < 200; i++) begin
            if (i % 17 == 0) st_();
            else if (i % 29 == 0) sp_();
            else if (i % 5 == 0) gap();
            else sb(8'(i * 37 + 8'hA3));
        end
        gap(); gap();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule